// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C master. After an external strobe reports that the START and the address have been sent, the block clocks data bytes in from the addressed slave. It drives SCL from a programmable divider, samples SDA, answers every byte with ACK or NACK, and builds a STOP condition when software asks for one. Both bus lines are open-drain. The block only ever pulls a line low or lets it go.

Software controls the block through three small registers: data, control and status. Reception is paced by software. A read of the data register while the block is waiting with SCL held low starts the next byte, and the very first such read is a dummy read. A hold control stops the transfer after the byte in progress. Software can therefore mark the final byte for NACK, collect the data and request STOP without any surplus byte being clocked in. Clearing the master bit returns the block to slave receive mode.

Top module: `i2c_master_rx`

Register map. The address is `regAddr`. Writes use `regWdata[3:0]`.

| Address | Register | Bits |
|---|---|---|
| 0 | data | read only: the last received byte |
| 1 | control | bit0 NACK-select (read/write), bit1 hold (read/write), bit2 master (reads the state, writing 0 clears it), bit3 busy (reads the state, writing 0 requests STOP), bit4 transmit-direction (read only) |
| 2 | status | bit0 data-full (read only), bit1 STOP-done (writing 0 clears it), bit2 transmit-end (read only), bit3 transmit-empty (read only) |

## Requirements
- R1: After reset, control reads 0x10 (transmit direction set, all other bits 0), status reads 0x0C (transmit-end and transmit-empty set), data reads 0, and neither SCL nor SDA is pulled low.
- R2: A pulse on `rxEnter` while the block is idle and not busy sets master (control bit2) and busy (control bit3), clears control bit4 (direction becomes receive), clears status bits 2 and 3, and pulls SCL low.
- R3: A read of address 0 while SCL is held low, hold is not latched and no STOP is pending starts one byte. The slave's bits are sampled at each SCL rising edge, MSB first, and the completed byte then reads back from address 0.
- R4: Status bit0 sets when a byte and its acknowledge bit have completed, and SCL then stays low. A read of address 0 clears status bit0.
- R5: During the ninth SCL pulse of each byte, SDA is pulled low when control bit0 was 0 at the end of the eighth data bit (ACK), and SDA is released when it was 1 (NACK).
- R6: When control bit1 is 1 as a byte completes, no further SCL pulses occur even if address 0 is read. Writing bit1 as 0 removes this hold.
- R7: With control bits 0 and 1 both set before the dummy read, exactly one byte (9 SCL pulses) is clocked in, and it is NACKed.
- R8: Writing control bit3 as 0 while busy produces a STOP once SCL is held low. SDA is pulled low, SCL is released, then SDA is released while SCL is high. The block then sets status bit1, clears busy and pulls neither line low.
- R9: Writing status bit1 as 0 clears it. Writing it as 1 leaves it unchanged.
- R10: Each SCL high pulse lasts `highCount` clock cycles (a count of 0 acts as 1). Each low phase within a byte lasts `lowCount` cycles.
- R11: Writing control bit2 as 0 makes it read 0, and later reads of address 0 clock no SCL pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEnter | input | 1 | Strobe: START and address done, enter master receive |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (reads of address 0 have side effects) |
| regWdata | input | 4 | Register write data |
| regRdata | output | BYTE_W | Register read data, combinational from regAddr |
| lowCount | input | DIV_W | SCL low-phase length in clocks |
| highCount | input | DIV_W | SCL high-phase length in clocks |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
A wrong state in the bit sequencer shows at the pins within one byte time. It appears as a miscounted number of SCL rising edges, a received byte shifted by one bit, or an acknowledge level on the wrong pulse. A hold flag that is lost or sticks shows as extra SCL pulses, or as a missing pulse, within one SCL period of the read that should or should not start a byte. A mistake in the STOP sequence shows as an SDA rise that is missing or happens while SCL is low, and status bit1 and the busy bit then read wrong on the next poll.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;

  localparam int WR_W = 4;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control write bit positions
  localparam int C_NACK   = 0;
  localparam int C_HOLD   = 1;
  localparam int C_MASTER = 2;
  localparam int C_BUSY   = 3;
  // status write bit position
  localparam int S_STOP   = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_BLOW,
    ST_BHIGH,
    ST_ALOW,
    ST_AHIGH,
    ST_ATAIL,
    ST_SLOW,
    ST_SHIGH
  } rxState_t;

  typedef struct packed {
    logic tmrLoadLow;
    logic tmrLoadHigh;
    logic shiftEn;
    logic bitClr;
    logic loadRx;
  } dpCmd_t;

  typedef struct packed {
    logic rxFull;
    logic stopDone;
    logic txEnd;
    logic txEmpty;
    logic nackSel;
    logic rcvHold;
    logic master;
    logic busy;
    logic dirTx;
    logic frozen;
    logic stopPend;
  } regFlags_t;

endpackage

// File: rtl/i2c_mrx_datapath.sv
module i2c_mrx_datapath
  import i2c_mrx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DIV_W-1:0]  lowCount,
  input  logic [DIV_W-1:0]  highCount,
  input  logic              sdaIn,
  output logic              tmrDone,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxData
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [DIV_W-1:0]  tmr;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftQ;
  logic [BYTE_W-1:0] rxQ;

  function automatic logic [DIV_W-1:0] phaseLoad(input logic [DIV_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // phase timer: loaded with count-1, done while zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (cmd.tmrLoadLow) begin
      tmr <= phaseLoad(lowCount);
    end else if (cmd.tmrLoadHigh) begin
      tmr <= phaseLoad(highCount);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

  assign tmrDone = (tmr == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shiftQ <= '0;
    end else begin
      if (cmd.bitClr) begin
        bitCnt <= '0;
      end else if (cmd.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (cmd.shiftEn) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaIn};
      end
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ <= '0;
    end else if (cmd.loadRx) begin
      rxQ <= shiftQ;
    end
  end

  assign rxData = rxQ;

endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
  import i2c_mrx_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxEnter,
  input  logic            dataRead,
  input  logic            ctrlWr,
  input  logic            statWr,
  input  logic [WR_W-1:0] wrBits,
  input  logic            tmrDone,
  input  logic            byteDone,
  output dpCmd_t          cmd,
  output regFlags_t       flags,
  output logic            sclOe,
  output logic            sdaOe
);

  rxState_t  state;
  rxState_t  stateNext;
  regFlags_t fl;
  logic      ackDrive;
  logic      byteFin;
  logic      stopFin;
  logic      enterOk;

  assign enterOk = rxEnter && (state == ST_IDLE) && !fl.busy;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    byteFin   = 1'b0;
    stopFin   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (enterOk) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (!fl.master) begin
          stateNext = ST_IDLE;
        end else if (fl.stopPend) begin
          stateNext      = ST_SLOW;
          cmd.tmrLoadLow = 1'b1;
        end else if (dataRead && !fl.frozen) begin
          stateNext      = ST_BLOW;
          cmd.tmrLoadLow = 1'b1;
          cmd.bitClr     = 1'b1;
        end
      end
      ST_BLOW: begin
        if (tmrDone) begin
          stateNext       = ST_BHIGH;
          cmd.tmrLoadHigh = 1'b1;
          cmd.shiftEn     = 1'b1;
        end
      end
      ST_BHIGH: begin
        if (tmrDone) begin
          stateNext      = byteDone ? ST_ALOW : ST_BLOW;
          cmd.tmrLoadLow = 1'b1;
        end
      end
      ST_ALOW: begin
        if (tmrDone) begin
          stateNext       = ST_AHIGH;
          cmd.tmrLoadHigh = 1'b1;
        end
      end
      ST_AHIGH: begin
        if (tmrDone) begin
          stateNext  = ST_ATAIL;
          cmd.loadRx = 1'b1;
          byteFin    = 1'b1;
        end
      end
      ST_ATAIL: begin
        stateNext = ST_HOLD;
      end
      ST_SLOW: begin
        if (tmrDone) begin
          stateNext       = ST_SHIGH;
          cmd.tmrLoadHigh = 1'b1;
        end
      end
      ST_SHIGH: begin
        if (tmrDone) begin
          stateNext = ST_IDLE;
          stopFin   = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_BHIGH && stateNext == ST_ALOW) begin
        ackDrive <= !fl.nackSel;
      end
    end
  end

  // register flags; later assignments take priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fl       <= '0;
      fl.dirTx <= 1'b1;
      fl.txEnd <= 1'b1;
      fl.txEmpty <= 1'b1;
    end else begin
      if (enterOk) begin
        fl.master   <= 1'b1;
        fl.busy     <= 1'b1;
        fl.dirTx    <= 1'b0;
        fl.txEnd    <= 1'b0;
        fl.txEmpty  <= 1'b0;
        fl.frozen   <= 1'b0;
        fl.stopPend <= 1'b0;
      end
      if (ctrlWr) begin
        fl.nackSel <= wrBits[C_NACK];
        fl.rcvHold <= wrBits[C_HOLD];
        if (!wrBits[C_HOLD])   fl.frozen <= 1'b0;
        if (!wrBits[C_MASTER]) fl.master <= 1'b0;
        if (!wrBits[C_BUSY] && fl.busy) fl.stopPend <= 1'b1;
      end
      if (statWr && !wrBits[S_STOP]) begin
        fl.stopDone <= 1'b0;
      end
      if (byteFin) begin
        fl.rxFull <= 1'b1;
        if (fl.rcvHold) fl.frozen <= 1'b1;
      end else if (dataRead) begin
        fl.rxFull <= 1'b0;
      end
      if (stopFin) begin
        fl.stopDone <= 1'b1;
        fl.busy     <= 1'b0;
        fl.stopPend <= 1'b0;
      end
    end
  end

  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    case (state)
      ST_HOLD, ST_BLOW:   sclOe = 1'b1;
      ST_ALOW, ST_ATAIL: begin
        sclOe = 1'b1;
        sdaOe = ackDrive;
      end
      ST_AHIGH:           sdaOe = ackDrive;
      ST_SLOW: begin
        sclOe = 1'b1;
        sdaOe = 1'b1;
      end
      ST_SHIGH:           sdaOe = 1'b1;
      default: begin
        sclOe = 1'b0;
        sdaOe = 1'b0;
      end
    endcase
  end

  assign flags = fl;

endmodule

// File: rtl/i2c_master_rx.sv
module i2c_master_rx
  import i2c_mrx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnter,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WR_W-1:0]   regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic [DIV_W-1:0]  lowCount,
  input  logic [DIV_W-1:0]  highCount,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe
);

  dpCmd_t            cmd;
  regFlags_t         flags;
  logic              tmrDone;
  logic              byteDone;
  logic [BYTE_W-1:0] rxData;
  logic              dataRead;
  logic              ctrlWr;
  logic              statWr;

  assign dataRead = regRd && (regAddr == ADDR_DATA);
  assign ctrlWr   = regWr && (regAddr == ADDR_CTRL);
  assign statWr   = regWr && (regAddr == ADDR_STAT);

  i2c_mrx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxEnter  (rxEnter),
    .dataRead (dataRead),
    .ctrlWr   (ctrlWr),
    .statWr   (statWr),
    .wrBits   (regWdata),
    .tmrDone  (tmrDone),
    .byteDone (byteDone),
    .cmd      (cmd),
    .flags    (flags),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe)
  );

  i2c_mrx_datapath #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .lowCount  (lowCount),
    .highCount (highCount),
    .sdaIn     (sdaIn),
    .tmrDone   (tmrDone),
    .byteDone  (byteDone),
    .rxData    (rxData)
  );

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdata = rxData;
      ADDR_CTRL: regRdata = BYTE_W'({flags.dirTx, flags.busy, flags.master,
                                     flags.rcvHold, flags.nackSel});
      ADDR_STAT: regRdata = BYTE_W'({flags.txEmpty, flags.txEnd,
                                     flags.stopDone, flags.rxFull});
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_mrx_checker.sv
module i2c_mrx_checker
  import i2c_mrx_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclOe,
  input logic      sdaOe,
  input logic      dataRead,
  input regFlags_t flags
);

  AST_FULL_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags.rxFull) |-> sclOe);  // R4

  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && sclOe) |=> !flags.rxFull);  // R4

  AST_FROZEN_NO_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (flags.frozen && flags.master && !flags.stopPend && sclOe) |=> sclOe);  // R6

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags.stopDone) |-> (!sclOe && !sdaOe && !flags.busy));  // R8

  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> sclOe);  // R8

endmodule

bind i2c_master_rx i2c_mrx_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclOe    (sclOe),
  .sdaOe    (sdaOe),
  .dataRead (dataRead),
  .flags    (flags)
);

// File: tb/i2c_master_rx_tb.sv
module i2c_master_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnter = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [3:0] regWdata = 4'd0;
  logic [7:0] regRdata;
  logic [7:0] lowCount = 8'd1;
  logic [7:0] highCount = 8'd1;
  logic       sclOe;
  logic       sdaOe;
  logic       scl;
  logic       sda;

  // slave model state
  logic [7:0] slvData [0:7];
  logic       ackRec [0:7];
  logic [3:0] slvBit = 4'd0;
  logic [3:0] slvIdx = 4'd0;
  logic       slvQuiet = 1'b0;
  logic       slvEn = 1'b0;
  logic       slvRst = 1'b0;
  logic       slvLow;
  int         sclRises = 0;
  int         stopCnt = 0;
  logic       measuring = 1'b0;
  int         expHi = 1;
  int         hiRun = 0;
  int         hiBad = 0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign slvLow = slvEn && !slvQuiet && (slvBit < 4'd8) &&
                  !slvData[slvIdx[2:0]][3'(4'd7 - slvBit)];
  assign scl = !sclOe;
  assign sda = !(sdaOe || slvLow);

  i2c_master_rx dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnter   (rxEnter),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .lowCount  (lowCount),
    .highCount (highCount),
    .sdaIn     (sda),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

  always @(negedge scl or posedge slvRst) begin
    if (slvRst) begin
      slvBit <= 4'd0;
      slvIdx <= 4'd0;
    end else if (slvBit == 4'd8) begin
      slvBit <= 4'd0;
      slvIdx <= slvIdx + 4'd1;
    end else begin
      slvBit <= slvBit + 4'd1;
    end
  end

  always @(posedge scl or posedge slvRst) begin
    if (slvRst) begin
      sclRises <= 0;
      slvQuiet <= 1'b0;
    end else begin
      sclRises <= sclRises + 1;
      if (slvBit == 4'd8) begin
        ackRec[slvIdx[2:0]] <= sda;
        if (sda) slvQuiet <= 1'b1;
      end
    end
  end

  always @(posedge sda or posedge slvRst) begin
    if (slvRst) stopCnt <= 0;
    else if (scl) stopCnt <= stopCnt + 1;
  end

  always @(negedge clk) begin
    if (!measuring) begin
      hiRun <= 0;
    end else if (scl) begin
      hiRun <= hiRun + 1;
    end else begin
      if (hiRun != 0 && hiRun != expHi) hiBad <= hiBad + 1;
      hiRun <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitStat(input int bitPos, input string tag);
    logic [7:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      rdReg(A_STAT, s);
      if (s[bitPos]) begin
        seen = 1'b1;
        break;
      end
    end
    chk(tag, int'(seen), 1);
  endtask

  task automatic doXfer(input int len, input int cfg, input int lo, input int hi);
    logic [7:0] d;
    int base;
    int hiBase;
    lowCount  = 8'(lo);
    highCount = 8'(hi);
    expHi     = (hi == 0) ? 1 : hi;
    for (int k = 0; k < 8; k++) begin
      if (cfg == 1) slvData[k] = (k % 2 == 1) ? 8'hFF : 8'h00;
      else slvData[k] = 8'(k * 53 + len * 29 + cfg * 71 + 165);
    end
    @(negedge clk); rxEnter = 1'b1;
    @(negedge clk); rxEnter = 1'b0;
    @(negedge clk); slvRst = 1'b1;
    @(negedge clk); slvRst = 1'b0; slvEn = 1'b1; measuring = 1'b1;
    hiBase = hiBad;

    rdReg(A_CTRL, d);
    chk("R2 ctrl after entry", int'(d & 8'h1C), 8'h0C);
    rdReg(A_STAT, d);
    chk("R2 tx flags after entry", int'(d[3:2]), 0);
    chk("R2 scl pulled low", int'(scl), 0);

    wrReg(A_CTRL, (len == 1) ? 4'hF : 4'hC);
    rdReg(A_DATA, d);  // dummy read starts the first byte
    for (int k = 0; k < len - 1; k++) begin
      waitStat(0, "R4 data-full sets");
      if (k == len - 2) wrReg(A_CTRL, 4'hF);
      rdReg(A_DATA, d);
      chk("R3 byte value", int'(d), int'(slvData[k]));
    end
    waitStat(0, "R4 data-full sets on last");
    rdReg(A_DATA, d);
    chk((len == 1) ? "R7 single byte value" : "R3 last byte value",
        int'(d), int'(slvData[len - 1]));
    rdReg(A_STAT, d);
    chk("R4 read clears full", int'(d[0]), 0);
    base = sclRises;
    repeat (60) @(negedge clk);
    chk("R6 no clocks while held", sclRises, base);
    chk((len == 1) ? "R7 exactly nine pulses" : "R6 pulse count",
        sclRises, 9 * len);
    chk("R4 scl stays low", int'(scl), 0);
    measuring = 1'b0;
    @(negedge clk);
    chk("R10 high pulse width", hiBad, hiBase);

    wrReg(A_CTRL, 4'h7);
    waitStat(1, "R8 stop-done sets");
    chk("R8 one stop on bus", stopCnt, 1);
    rdReg(A_CTRL, d);
    chk("R8 busy cleared", int'(d[3]), 0);
    chk("R8 lines released", int'({scl, sda}), 3);
    for (int k = 0; k < len; k++) begin
      chk((len == 1) ? "R7 nack on only byte" : "R5 ack level",
          int'(ackRec[k]), (k == len - 1) ? 1 : 0);
    end
    slvEn = 1'b0;

    wrReg(A_STAT, 4'h2);
    rdReg(A_STAT, d);
    chk("R9 write one keeps stop-done", int'(d[1]), 1);
    wrReg(A_STAT, 4'h0);
    rdReg(A_STAT, d);
    chk("R9 write zero clears stop-done", int'(d[1]), 0);

    wrReg(A_CTRL, 4'h0);
    rdReg(A_CTRL, d);
    chk("R11 master cleared", int'(d[2]), 0);
    base = sclRises;
    rdReg(A_DATA, d);
    repeat (30) @(negedge clk);
    chk("R11 no clocks in slave mode", sclRises, base);
  endtask

  initial begin
    logic [7:0] d;
    int los [0:3];
    int his [0:3];
    los[0] = 1; his[0] = 1;
    los[1] = 2; his[1] = 3;
    los[2] = 4; his[2] = 2;
    los[3] = 0; his[3] = 0;
    for (int k = 0; k < 8; k++) begin
      slvData[k] = 8'h00;
      ackRec[k]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(A_CTRL, d);
    chk("R1 ctrl reset", int'(d), 8'h10);
    rdReg(A_STAT, d);
    chk("R1 status reset", int'(d), 8'h0C);
    rdReg(A_DATA, d);
    chk("R1 data reset", int'(d), 0);
    chk("R1 lines released", int'({scl, sda}), 3);

    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int len = 1; len <= 4; len++) begin
        doXfer(len, cfg, los[cfg], his[cfg]);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule